// File: doc/BRIEF.md
# Lane Loss-of-Signal Squelch Controller

This block supervises a group of serial lanes. Each lane delivers a one-cycle strobe for every transition that the front end detects on its input. A per-lane cycle counter measures how long the lane has been silent. When the silence reaches the selected window, the lane enters loss of signal (LOS), and its alarm bit goes high. If automatic squelch is enabled, the lane's output is also steered to an inhibit level. The window is either about 1 µs or about 5 µs, both derived from a reference-clock parameter. The inhibit level is programmable as driven low, driven high or the idle common-mode level. A per-lane manual squelch forces the inhibit level whatever the lane's LOS status.

An optional electrical-idle mode is provided for links that signal with idle periods. With this mode enabled, a lane that stays in LOS past the long window moves to an electrical-idle state. In that state its output sits at common mode, and the lane lets the first data burst through in the same cycle as its first strobe.

Each lane runs a three-state machine. The states are LN_LIVE (data seen within the window), LN_LOS (window expired) and LN_EIDLE (idle pass-through). The transitions are named as follows:
- **expire**: LN_LIVE to LN_LOS, when the silent count reaches the selected window.
- **recover**: LN_LOS or LN_EIDLE to LN_LIVE, on any strobe.
- **idle_enter**: LN_LOS to LN_EIDLE, when the idle mode is enabled and the count is already at the long window with no strobe.
- **idle_leave**: LN_EIDLE to LN_LOS, when the idle mode is disabled.

The output select codes are:

| Code | Output state |
|---|---|
| 00 | pass data |
| 01 | drive low |
| 10 | drive high |
| 11 | idle common mode |

Top module: `los_squelch_ctrl`

## Requirements
- R1: While rst_n is low, and after its release until a strobe arrives, every lane is in LOS with its alarm bit set to 1.
- R2: With tmo_short=0, a lane that has been live raises its alarm at the clock edge that completes 5*CYC_PER_US consecutive cycles without a strobe, and not before.
- R3: With tmo_short=1, the same happens after 1*CYC_PER_US silent cycles.
- R4: A strobe on a lane in LOS clears its alarm at the next clock edge, and the lane's output returns to code 00 (data) at that edge.
- R5: With sq_auto_en=1, a lane in LOS with no manual squelch drives the inhibit code selected by inh_lvl.
- R6: With sq_auto_en=0, a lane in LOS still sets its alarm, but its output stays at code 00.
- R7: Inhibit mapping: inh_lvl 00 gives output code 01 (low), 01 gives code 10 (high), and 10 or 11 give code 11 (common mode).
- R8: sq_force[i]=1 drives lane i to the inhibit code of R7 whether or not the lane is in LOS.
- R9: Lane i drives alarm bit i and output bits [2i+1:2i], and a lane is not affected by the strobes of the other lanes.
- R10: With eidle_en=1, a lane still silent one cycle after its count reaches the long window enters the idle state. In that state its output is code 11, regardless of sq_auto_en and inh_lvl, and its alarm stays at 1.
- R11: In the idle state, a strobe on the lane gives output code 00 in the same cycle, before the clock edge.
- R12: Clearing eidle_en returns an idle lane to plain LOS at the next edge, after which R5 or R6 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trans_strb | input | LANES | Per-lane transition strobe |
| tmo_short | input | 1 | 0: about 5 µs window, 1: about 1 µs window |
| sq_auto_en | input | 1 | Enable automatic squelch in LOS |
| inh_lvl | input | 2 | Inhibit level select |
| sq_force | input | LANES | Per-lane manual squelch |
| eidle_en | input | 1 | Enable electrical-idle pass-through |
| out_sel | output | 2*LANES | Per-lane output state code |
| los_alarm | output | LANES | Per-lane LOS alarm, lane i on bit i |

## Verification
The bench targets the exact edge of each window. A design that expires one cycle early or late, or that keeps using the long window after tmo_short is set, disagrees with the model on that one cycle. One lane is silenced while the others keep toggling, to expose any alarm or output crossed between lanes. The idle mode is entered, left by disabling it, and left by a strobe. The same-cycle check catches a design that registers the idle bypass, and the follow-up checks catch one that keeps forcing common mode once eidle_en is off. Manual squelch is applied to a live lane, to catch a design that gates the override on LOS.

// File: rtl/los_sq_pkg.sv
package los_sq_pkg;

    typedef enum logic [1:0] {
        LN_LIVE  = 2'd0,
        LN_LOS   = 2'd1,
        LN_EIDLE = 2'd2
    } lane_st_e;

    typedef enum logic [1:0] {
        OS_DATA = 2'd0,
        OS_LOW  = 2'd1,
        OS_HIGH = 2'd2,
        OS_CM   = 2'd3
    } out_sel_e;

    function automatic out_sel_e inh_code(input logic [1:0] lvl);
        out_sel_e r;
        unique case (lvl)
            2'd0:    r = OS_LOW;
            2'd1:    r = OS_HIGH;
            default: r = OS_CM;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/los_lane_fsm.sv
module los_lane_fsm
    import los_sq_pkg::*;
#(
    parameter int T_SHORT = 8,
    parameter int T_LONG  = 40,
    localparam int CW     = $clog2(T_LONG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb,
    input  logic          tmo_short,
    input  logic          eidle_en,
    output lane_st_e      st_q,
    output logic [CW-1:0] cnt_q
);

    localparam logic [CW-1:0] TS = CW'(T_SHORT);
    localparam logic [CW-1:0] TL = CW'(T_LONG);

    lane_st_e      st_d;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] term;

    always_comb begin
        cnt_inc = (cnt_q == TL) ? cnt_q : cnt_q + 1'b1;
        term    = tmo_short ? TS : TL;
        cnt_d   = strb ? '0 : cnt_inc;
        st_d    = st_q;
        unique case (st_q)
            LN_LIVE: begin
                if (!strb && cnt_inc >= term) st_d = LN_LOS;        // expire
            end
            LN_LOS: begin
                if (strb)                             st_d = LN_LIVE;   // recover
                else if (eidle_en && cnt_q == TL)     st_d = LN_EIDLE;  // idle_enter
            end
            LN_EIDLE: begin
                if (strb)           st_d = LN_LIVE;                  // recover
                else if (!eidle_en) st_d = LN_LOS;                   // idle_leave
            end
            default: st_d = LN_LOS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LN_LOS;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R4: any strobe brings the lane live at the next edge
    assert_strobe_recovers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> st_q == LN_LIVE);

    // R2: with the long window held, expiry happens exactly at the long count
    assert_long_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_LOS && $past(st_q) == LN_LIVE && !tmo_short && $past(!tmo_short))
        |-> cnt_q == TL);

    // R3: with the short window held, expiry never precedes the short count
    assert_short_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_LOS && $past(st_q) == LN_LIVE) |-> cnt_q >= TS);

    // R10: the idle state is reached only while the idle mode was enabled
    assert_idle_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_EIDLE) |-> $past(eidle_en));

endmodule

// File: rtl/los_out_mux.sv
module los_out_mux
    import los_sq_pkg::*;
(
    input  lane_st_e   st,
    input  logic       strb,
    input  logic       auto_en,
    input  logic [1:0] inh_lvl,
    input  logic       force_sq,
    output out_sel_e   sel,
    output logic       alarm
);

    always_comb begin
        alarm = (st != LN_LIVE);
        if (force_sq) begin
            sel = inh_code(inh_lvl);
        end else begin
            unique case (st)
                LN_LIVE:  sel = OS_DATA;
                LN_LOS:   sel = auto_en ? inh_code(inh_lvl) : OS_DATA;
                LN_EIDLE: sel = strb ? OS_DATA : OS_CM;
                default:  sel = OS_CM;
            endcase
        end
    end

endmodule

// File: rtl/los_squelch_ctrl.sv
module los_squelch_ctrl
    import los_sq_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int CYC_PER_US = 8,
    parameter int SHORT_US   = 1,
    parameter int LONG_US    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   trans_strb,
    input  logic               tmo_short,
    input  logic               sq_auto_en,
    input  logic [1:0]         inh_lvl,
    input  logic [LANES-1:0]   sq_force,
    input  logic               eidle_en,
    output logic [2*LANES-1:0] out_sel,
    output logic [LANES-1:0]   los_alarm
);

    localparam int T_SHORT = SHORT_US * CYC_PER_US;
    localparam int T_LONG  = LONG_US * CYC_PER_US;
    localparam int CW      = $clog2(T_LONG + 1);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_st_e      st;
        logic [CW-1:0] cnt;
        out_sel_e      sel;
        logic          alm;

        los_lane_fsm #(.T_SHORT(T_SHORT), .T_LONG(T_LONG)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .strb      (trans_strb[i]),
            .tmo_short (tmo_short),
            .eidle_en  (eidle_en),
            .st_q      (st),
            .cnt_q     (cnt)
        );

        los_out_mux u_mux (
            .st       (st),
            .strb     (trans_strb[i]),
            .auto_en  (sq_auto_en),
            .inh_lvl  (inh_lvl),
            .force_sq (sq_force[i]),
            .sel      (sel),
            .alarm    (alm)
        );

        assign out_sel[2*i +: 2] = sel;
        assign los_alarm[i]      = alm;

        // R8: manual squelch never lets data through
        assert_force_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            sq_force[i] |-> out_sel[2*i +: 2] != 2'b00);

        // R6: with auto squelch off, a plain LOS lane keeps passing data
        assert_auto_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!sq_auto_en && !sq_force[i] && st == LN_LOS) |-> out_sel[2*i +: 2] == 2'b00);

        // R4: one edge after a strobe the alarm is clear
        assert_alarm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            trans_strb[i] |=> !los_alarm[i]);

        // R11: an idle lane's output follows its strobe combinationally
        assert_idle_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (st == LN_EIDLE && !sq_force[i]) |-> (out_sel[2*i +: 2] == (trans_strb[i] ? 2'b00 : 2'b11)));
    end

endmodule

// File: tb/tb_los_squelch_ctrl.sv
module tb_los_squelch_ctrl;

    localparam int LANES = 4;
    localparam int CPU   = 8;
    localparam int TS    = CPU;
    localparam int TL    = 5 * CPU;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LANES-1:0]   trans_strb = '0;
    logic               tmo_short = 1'b0;
    logic               sq_auto_en = 1'b1;
    logic [1:0]         inh_lvl = 2'b00;
    logic [LANES-1:0]   sq_force = '0;
    logic               eidle_en = 1'b0;
    logic [2*LANES-1:0] out_sel;
    logic [LANES-1:0]   los_alarm;

    los_squelch_ctrl #(.LANES(LANES), .CYC_PER_US(CPU)) dut (
        .clk, .rst_n, .trans_strb, .tmo_short, .sq_auto_en, .inh_lvl,
        .sq_force, .eidle_en, .out_sel, .los_alarm
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    int sil [LANES];
    bit los [LANES];
    bit eid [LANES];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int inh_of(input logic [1:0] lvl);
        return (lvl == 2'd0) ? 1 : (lvl == 2'd1) ? 2 : 3;
    endfunction

    function automatic int exp_sel(input int i);
        if (sq_force[i]) return inh_of(inh_lvl);
        if (eid[i])      return trans_strb[i] ? 0 : 3;
        if (los[i])      return sq_auto_en ? inh_of(inh_lvl) : 0;
        return 0;
    endfunction

    task automatic compare();
        for (int i = 0; i < LANES; i++) begin
            int a_sel = int'(out_sel[2*i +: 2]);
            int e_sel = exp_sel(i);
            checks += 2;
            if (los_alarm[i] !== los[i]) begin
                errors++;
                $display("FAIL %s lane %0d alarm actual %0b expected %0b", cur_req, i, los_alarm[i], los[i]);
            end
            if (a_sel != e_sel) begin
                errors++;
                $display("FAIL %s lane %0d out_sel actual %0d expected %0d", cur_req, i, a_sel, e_sel);
            end
        end
    endtask

    task automatic model_edge();
        for (int i = 0; i < LANES; i++) begin
            if (!rst_n) begin
                sil[i] = 0; los[i] = 1; eid[i] = 0;
            end else if (trans_strb[i]) begin
                sil[i] = 0; los[i] = 0; eid[i] = 0;
            end else begin
                bit was_los = los[i];
                sil[i] = sil[i] + 1;
                if (!los[i] && sil[i] >= (tmo_short ? TS : TL)) los[i] = 1;
                eid[i] = eidle_en && (eid[i] || (was_los && sil[i] >= TL + 1));
            end
        end
    endtask

    // drive strobes, compare before the edge, then advance the model with the edge
    task automatic step(input logic [LANES-1:0] s);
        trans_strb = s;
        #2;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic run(input logic [LANES-1:0] s, input int n);
        for (int k = 0; k < n; k++) step(s);
    endtask

    // toggle the selected lanes every third cycle for n cycles
    task automatic toggle(input logic [LANES-1:0] lanes, input int n);
        for (int k = 0; k < n; k++) step((k % 3 == 0) ? lanes : '0);
    endtask

    initial begin
        for (int i = 0; i < LANES; i++) begin sil[i] = 0; los[i] = 1; eid[i] = 0; end
        @(negedge clk);
        cur_req = "R1";
        run('0, 4);
        rst_n = 1'b1;
        run('0, 3);

        cur_req = "R4";
        step(4'hF);
        toggle(4'hF, 30);

        cur_req = "R2 R9";
        step(4'hF);
        toggle(4'b1011, TL + 6);

        cur_req = "R4 R9";
        step(4'b0100);
        toggle(4'hF, 9);

        cur_req = "R3";
        tmo_short = 1'b1;
        step(4'hF);
        run('0, TS + 4);

        cur_req = "R5 R7";
        for (int l = 0; l < 4; l++) begin
            inh_lvl = 2'(l);
            run('0, 2);
        end

        cur_req = "R6";
        sq_auto_en = 1'b0;
        run('0, 3);
        sq_auto_en = 1'b1;

        cur_req = "R8";
        inh_lvl = 2'b01;
        step(4'hF);
        sq_force = 4'b0010;
        toggle(4'hF, 6);
        sq_force = '0;
        toggle(4'hF, 3);

        cur_req = "R10";
        tmo_short = 1'b0;
        eidle_en = 1'b1;
        inh_lvl = 2'b00;
        step(4'hF);
        run('0, TL + 5);
        sq_auto_en = 1'b0;
        run('0, 2);

        cur_req = "R11";
        step(4'b0001);
        run('0, 2);

        cur_req = "R12";
        eidle_en = 1'b0;
        run('0, 3);
        sq_auto_en = 1'b1;
        run('0, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule